// File: doc/BRIEF.md
# PWM Audio Sample DAC

This block converts a stream of unsigned audio samples into a single-bit pulse-width-modulated line. The line is meant to drive a speaker through an external low-pass filter. A free-running period counter advances once per enabled clock cycle. Each full counter period plays exactly one sample. The output is high for as many counts as the sample value and low for the rest of the period.

Sample advance is tied to the counter wrap. In the last count of each period the block raises a one-cycle request. A source that presents a sample with valid high in that same cycle has it captured for the next period. If the source presents nothing, the previous sample plays again.

The clock enable lets a fast system clock produce the required count rate. For an 8 kHz sample rate at 8-bit resolution, enabled cycles must occur at 256 × 8000 = 2.048 MHz.

Top module: `pwm_audio_dac`

## Requirements
- R1: Synchronous active-high reset clears the period count and the held level to 0. While reset is held, and after it is released until the first enabled edge, `pwm_o` is 0 and `req_o` is 0.
- R2: The period count advances by one on each clock edge with `en_i` high. It goes 0, 1, … 255 and then back to 0. On edges with `en_i` low, the count, the held level and `pwm_o` all keep their values.
- R3: After each enabled edge, `pwm_o` is 1 exactly when the new count is less than the new held level. For level L, the period therefore shows L high counts followed by 256−L low counts.
- R4: A held level of 0 keeps `pwm_o` low for the whole period. A level of 255 gives high for counts 0..254 and low only at count 255.
- R5: `req_o` is high exactly in the cycles where `en_i` is high and the count is 255. This gives one request per 256 enabled cycles, and the request never lasts two cycles in a row.
- R6: When `req_o` and `valid_i` are both high in a cycle, `sample_i` becomes the held level at that clock edge. The level then stays fixed until the next wrap.
- R7: When `req_o` is high and `valid_i` is low, the held level is kept, so the previous sample plays again for the next period.
- R8: When `valid_i` is high but `req_o` is low, `sample_i` has no effect on the held level or on `pwm_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Count enable; one enabled cycle is one PWM count |
| sample_i | input | 8 | Unsigned audio sample offered by the source |
| valid_i | input | 1 | Marks `sample_i` as valid |
| pwm_o | output | 1 | Registered pulse-width-modulated output |
| req_o | output | 1 | Request for the next sample, high in the final count of a period |

## Verification
On every cycle, the assertions check four things:
- the counter steps and wraps correctly, and holds while disabled;
- the held level changes only at a wrap, and only when valid is high;
- the output agrees with the comparison of count and level;
- a zero level gives a low line, and a request never lasts two cycles.

Only the bench scenarios can show the end-to-end results:
- that a sample handed over on a request shapes the whole next period;
- that a missing sample makes the previous one repeat;
- that stray valid pulses outside a request are ignored;
- that a throttled enable stretches each period without changing its duty.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

    // Default resolution of the converter in bits.
    localparam int unsigned LEVEL_W_DEF = 8;

    // Count value that closes a period, for a given width.
    function automatic int unsigned period_last(input int unsigned w);
        return (1 << w) - 1;
    endfunction

    // Shared view of one count step.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_WRAP = 2'd2
    } step_kind_e;

endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter
    import pwm_dac_pkg::*;
#(
    parameter int unsigned W = LEVEL_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(period_last(W));

    step_kind_e step;

    always_comb begin
        if (!en)              step = STEP_HOLD;
        else if (cnt_q == LAST) step = STEP_WRAP;
        else                  step = STEP_INC;
    end

    always_comb begin
        unique case (step)
            STEP_INC:  cnt_d = cnt_q + W'(1);
            STEP_WRAP: cnt_d = '0;
            default:   cnt_d = cnt_q;
        endcase
    end

    assign wrap = (step == STEP_WRAP);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R2: count steps by one on enabled cycles below the last value
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + W'(1)));
    // R2: last value returns to zero
    p_count_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_q == LAST) |=> (cnt_q == '0));
    // R2: disabled cycle holds the count
    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_level_hold.sv
module pwm_level_hold
    import pwm_dac_pkg::*;
#(
    parameter int unsigned W = LEVEL_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wrap,
    input  logic         valid,
    input  logic [W-1:0] sample,
    output logic [W-1:0] lvl_q,
    output logic [W-1:0] lvl_d
);
    logic take;

    assign take  = wrap && valid;
    assign lvl_d = take ? sample : lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl_d;
    end

    // R6: a wrap with valid loads the offered sample
    p_level_load_r6: assert property (@(posedge clk) disable iff (rst)
        (wrap && valid) |=> (lvl_q == $past(sample)));
    // R7: a wrap without valid repeats the old level
    p_level_repeat_r7: assert property (@(posedge clk) disable iff (rst)
        (wrap && !valid) |=> $stable(lvl_q));
    // R8: no change of level away from a wrap
    p_level_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(lvl_q));

endmodule

// File: rtl/pwm_duty_compare.sv
module pwm_duty_compare
    import pwm_dac_pkg::*;
#(
    parameter int unsigned W = LEVEL_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] cnt_d,
    input  logic [W-1:0] lvl_d,
    output logic         pwm_q
);
    always_ff @(posedge clk) begin
        if (rst)     pwm_q <= 1'b0;
        else if (en) pwm_q <= (cnt_d < lvl_d);
    end

    // R2: the line is frozen on disabled cycles
    p_pwm_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pwm_q));

endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
    import pwm_dac_pkg::*;
#(
    parameter int unsigned W = LEVEL_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] sample_i,
    input  logic         valid_i,
    output logic         pwm_o,
    output logic         req_o
);
    logic [W-1:0] cnt_q, cnt_d, lvl_q, lvl_d;
    logic         wrap;

    pwm_period_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .en(en_i),
        .cnt_q(cnt_q), .cnt_d(cnt_d), .wrap(wrap)
    );

    pwm_level_hold #(.W(W)) u_lvl (
        .clk(clk), .rst(rst), .wrap(wrap), .valid(valid_i),
        .sample(sample_i), .lvl_q(lvl_q), .lvl_d(lvl_d)
    );

    pwm_duty_compare #(.W(W)) u_cmp (
        .clk(clk), .rst(rst), .en(en_i),
        .cnt_d(cnt_d), .lvl_d(lvl_d), .pwm_q(pwm_o)
    );

    assign req_o = wrap;

    // R3: registered line agrees with count against level
    p_pwm_match_r3: assert property (@(posedge clk) disable iff (rst)
        pwm_o == (cnt_q < lvl_q));
    // R4: zero level keeps the line low
    p_zero_low_r4: assert property (@(posedge clk) disable iff (rst)
        (lvl_q == '0) |-> !pwm_o);
    // R5: a request is never two cycles long
    p_req_single_r5: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);
    // R5: a request is followed by a count of zero
    p_req_zero_r5: assert property (@(posedge clk) disable iff (rst)
        req_o |=> (cnt_q == '0));

endmodule

// File: tb/tb_pwm_audio_dac.sv
module tb_pwm_audio_dac;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0;
    logic [7:0] sample_i = '0;
    logic       valid_i = 1'b0;
    logic       pwm_o, req_o;

    int checks = 0;
    int fails  = 0;
    int periods_done = 0;
    int cyc = 0;
    bit finished = 0;

    pwm_audio_dac dut (
        .clk(clk), .rst(rst), .en_i(en_i), .sample_i(sample_i),
        .valid_i(valid_i), .pwm_o(pwm_o), .req_o(req_o)
    );

    always #2.5 clk = ~clk;

    // scoreboard of expected per-period levels and their requirement tags
    int    exp_q[$];
    string tag_q[$];

    localparam int N = 11;
    int  lv_tab   [N] = '{0, 255, 128, 1, 254, 37, 0, 90, 200, 3, 0};
    bit  val_tab  [N] = '{1, 1, 1, 1, 1, 1, 0, 1, 1, 1, 1};
    bit  junk_tab [N] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
    bit  thr_tab  [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0};
    string t_tab  [N] = '{"R4", "R4", "R6", "R3", "R3", "R8", "R7", "R6", "R2", "R2", "R4"};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // driver: enable pattern, reset, and sample handover on requests
    initial begin
        int  idx = 0;
        int  last = 0;
        bit  junk = 0;
        bit  thr = 0;
        en_i = 1'b1;
        repeat (4) @(negedge clk);
        check(pwm_o == 1'b0, "R1", pwm_o, 0);
        check(req_o == 1'b0, "R1", req_o, 0);
        rst = 1'b0;
        exp_q.push_back(0);
        tag_q.push_back("R1");
        forever begin
            @(negedge clk);
            cyc++;
            en_i = thr ? (cyc % 3 != 0) : 1'b1;
            #1;
            if (req_o) begin
                if (idx < N) begin
                    valid_i  = val_tab[idx];
                    sample_i = val_tab[idx] ? 8'(lv_tab[idx]) : 8'h5C;
                    if (val_tab[idx]) last = lv_tab[idx];
                    exp_q.push_back(last);
                    tag_q.push_back(t_tab[idx]);
                    junk = junk_tab[idx];
                    thr  = thr_tab[idx];
                    idx++;
                end else begin
                    valid_i = 1'b0;
                    exp_q.push_back(last);
                    tag_q.push_back("R7");
                    junk = 0;
                    thr  = 0;
                end
            end else begin
                valid_i  = junk;
                sample_i = junk ? 8'hA5 : 8'h00;
            end
        end
    end

    // monitor: independent model of count and level, one verdict per period
    initial begin
        int    k = 0;
        int    cur = 0;
        string tag = "R1";
        int    bad = 0;
        int    act_s = 0, exp_s = 0;
        int    rbad = 0;
        wait (!rst);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
        while (periods_done < N + 1) begin
            @(posedge clk);
            #1;
            if (en_i) begin
                if (k == 255) begin
                    check(bad == 0, tag, act_s, exp_s);           // R3 duty shape per period
                    check(rbad == 0, "R5", rbad, 0);              // R5 request placement
                    periods_done++;
                    bad = 0; rbad = 0;
                    k = 0;
                    if (exp_q.size() > 0) begin
                        cur = exp_q.pop_front();
                        tag = tag_q.pop_front();
                    end
                end else begin
                    k++;
                end
            end
            if (pwm_o != (k < cur)) begin
                if (bad == 0) begin act_s = pwm_o; exp_s = (k < cur); end
                bad++;
            end
            @(negedge clk);
            #2;
            if (req_o != (en_i && k == 255)) rbad++;
        end
        finish_run();
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end
endmodule